// File: doc/BRIEF.md
# Serial Packet Receiver Framer

This block takes a sampled serial bit stream from a shared single-wire medium and turns it into framed packets. A bit is taken only when its valid strobe is high while the carrier indication is up. Bits are gathered least significant bit first into bytes. Each frame starts with a three-byte header: a destination station byte, a source station byte and a length byte. The header is followed by as many payload bytes as the length byte gives, from 0 to 255, and then one check byte.

The destination byte is compared with the local station address, and the all-ones broadcast value is also accepted. When a frame is accepted, its header and payload bytes go out through a byte-wide write port to an external buffer, addressed by their position in the frame. When the frame ends, one pulse reports whether it was good, failed its check, or was cut short by a carrier drop. A frame for another station writes nothing and reports nothing. The block ignores all further input until the carrier falls.

Top module: `pkt_rx_framer`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, wr_en and done are 0 and status is 2'b00. The block then waits for carrier.
- R2: The first accepted bit of a byte becomes bit 0 and the eighth becomes bit 7. A bit is accepted only when bit_valid and carrier are both high, and cycles that fail this do not shift the assembly.
- R3: A frame is accepted only when its destination byte equals station_addr or 8'hFF. A frame with any other destination produces no write and no done pulse.
- R4: Each header and payload byte of an accepted frame is written once. Its wr_addr is its position in the frame modulo 256, with the destination byte at 0, so the last two payload bytes of a 255-byte payload land at 0 and 1. The check byte is never written.
- R5: The byte at header position 2 gives the payload count, from 0 to 255. The byte after that many payload bytes is taken as the check byte.
- R6: The check is a CRC-8 with polynomial 0x07 and start value 0x00, taken most significant bit first over each header and payload byte value. When it equals the check byte, the frame ends with done and status 2'b01 (good).
- R7: When the computed check differs from the received check byte, the frame ends with done and status 2'b10 (check error).
- R8: If carrier falls after an accepted destination byte but before the check byte is complete, done rises with status 2'b11 (runt). The writes already made stand, and no further write follows.
- R9: done lasts exactly one cycle, and there is at most one done per frame. Status is 2'b00 whenever done is low, and no write coincides with done.
- R10: After a frame ends, or is filtered out, bytes arriving while carrier stays high produce no write and no done. The next frame starts only after carrier has been low.
- R11: If carrier falls before the first byte is complete, there is no done and no write. The partial bits are dropped, so the next frame starts byte assembly afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| station_addr | input | 8 | Local station address |
| carrier | input | 1 | Carrier present on the medium |
| bit_valid | input | 1 | Strobe: bit_data holds a sampled bit this cycle |
| bit_data | input | 1 | Sampled line bit |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 8 | Buffer write address (byte position in frame) |
| wr_data | output | 8 | Buffer write data |
| done | output | 1 | One-cycle end-of-frame pulse |
| status | output | 2 | Frame outcome with done: 01 good, 10 check error, 11 runt |

## Verification
Every destination value from 0x00 to 0xFF is sent against a fixed station address. This separates the exact match, the broadcast value and every near miss. Payload lengths are swept from 0 to 24 and include 255, with back-to-back bits and with idle strobe gaps that carry junk data. These runs show that the length field, the address wrap and the bit order are right. Flipped check bytes separate a good frame from a check error. A frame cut after each byte position separates a silent drop (before the destination is complete) from a runt report. Trailing bytes after the check byte, and stray bits before carrier or with carrier low, show that such input leaves the buffer and the status untouched.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RX_NONE    = 2'b00,
    RX_GOOD    = 2'b01,
    RX_CRC_BAD = 2'b10,
    RX_RUNT    = 2'b11
  } rx_status_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_CHK,
    ST_SKIP
  } rx_state_e;

  // One byte through a CRC-8, most significant bit first.
  function automatic logic [BYTE_W-1:0] crc8_step(
    input logic [BYTE_W-1:0] crc_in,
    input logic [BYTE_W-1:0] data,
    input logic [BYTE_W-1:0] poly
  );
    logic [BYTE_W-1:0] c;
    c = crc_in ^ data;
    for (int i = 0; i < BYTE_W; i++) begin
      if (c[BYTE_W-1]) c = (c << 1) ^ poly;
      else             c = c << 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_deser.sv
module rxf_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         carrier,
  input  logic         bit_valid,
  input  logic         bit_data,
  output logic         byte_stb,
  output logic [W-1:0] byte_q
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;
  logic          take;

  assign take = bit_valid && carrier;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shreg    <= '0;
      byte_stb <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (!carrier) begin
        cnt <= '0;
      end else if (take) begin
        shreg <= {bit_data, shreg[W-1:1]};
        if (cnt == LAST) begin
          cnt      <= '0;
          byte_stb <= 1'b1;
          byte_q   <= {bit_data, shreg[W-1:1]};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(bit_valid && carrier));
endmodule

// File: rtl/rxf_crc_acc.sv
module rxf_crc_acc
  import rxf_pkg::*;
#(
  parameter logic [BYTE_W-1:0] POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (en)    crc <= crc8_step(crc, data, POLY);
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic [BYTE_W-1:0] station_addr,
  input  logic [BYTE_W-1:0] crc_val,
  output logic              crc_clr,
  output logic              crc_en,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              done,
  output rx_status_e        status
);
  rx_state_e         state;
  logic [1:0]        hdr_pos;
  logic [ADDR_W-1:0] idx;
  logic [BYTE_W-1:0] rem;
  logic              addr_hit;
  logic              in_frame;

  generate
    if (BCAST_EN) begin : g_bcast
      assign addr_hit = (byte_q == station_addr) || (byte_q == {BYTE_W{1'b1}});
    end else begin : g_unicast
      assign addr_hit = (byte_q == station_addr);
    end
  endgenerate

  assign in_frame = (state == ST_HDR) || (state == ST_DATA);
  assign crc_clr  = (state == ST_IDLE);
  assign crc_en   = byte_stb && in_frame && !((state == ST_HDR) && (hdr_pos == 2'd0) && !addr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hdr_pos <= 2'd0;
      idx     <= '0;
      rem     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
      status  <= RX_NONE;
    end else begin
      wr_en  <= 1'b0;
      done   <= 1'b0;
      status <= RX_NONE;
      case (state)
        ST_IDLE: begin
          if (carrier) begin
            state   <= ST_HDR;
            hdr_pos <= 2'd0;
            idx     <= '0;
          end
        end
        ST_HDR: begin
          if (byte_stb) begin
            if ((hdr_pos == 2'd0) && !addr_hit) begin
              state <= ST_SKIP;
            end else begin
              wr_en   <= 1'b1;
              wr_addr <= idx;
              wr_data <= byte_q;
              idx     <= idx + 1'b1;
              hdr_pos <= hdr_pos + 2'd1;
              if (hdr_pos == 2'd2) begin
                rem   <= byte_q;
                state <= (byte_q == '0) ? ST_CHK : ST_DATA;
              end
            end
          end else if (!carrier) begin
            if (hdr_pos != 2'd0) begin
              done   <= 1'b1;
              status <= RX_RUNT;
            end
            state <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (byte_stb) begin
            wr_en   <= 1'b1;
            wr_addr <= idx;
            wr_data <= byte_q;
            idx     <= idx + 1'b1;
            rem     <= rem - 1'b1;
            if (rem == 8'd1) state <= ST_CHK;
          end else if (!carrier) begin
            done   <= 1'b1;
            status <= RX_RUNT;
            state  <= ST_IDLE;
          end
        end
        ST_CHK: begin
          if (byte_stb) begin
            done   <= 1'b1;
            status <= (byte_q == crc_val) ? RX_GOOD : RX_CRC_BAD;
            state  <= ST_SKIP;
          end else if (!carrier) begin
            done   <= 1'b1;
            status <= RX_RUNT;
            state  <= ST_IDLE;
          end
        end
        ST_SKIP: begin
          if (!carrier) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (status == RX_NONE));
  // R9
  write_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !done);
  // R10
  skip_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !wr_en);
  // R5
  data_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (rem != '0));
  // R8
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && $past(state != ST_HDR)) |-> !wr_en);
endmodule

// File: rtl/pkt_rx_framer.sv
module pkt_rx_framer #(
  parameter int ADDR_W = 8,
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        station_addr,
  input  logic              carrier,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic [1:0]        status
);
  import rxf_pkg::*;

  logic              byte_stb;
  logic [BYTE_W-1:0] byte_q;
  logic [BYTE_W-1:0] crc_val;
  logic              crc_clr;
  logic              crc_en;
  rx_status_e        status_e;

  rxf_deser #(.W(BYTE_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .carrier   (carrier),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .byte_stb  (byte_stb),
    .byte_q    (byte_q)
  );

  rxf_crc_acc #(.POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (crc_clr),
    .en    (crc_en),
    .data  (byte_q),
    .crc   (crc_val)
  );

  rxf_ctrl #(.ADDR_W(ADDR_W), .BCAST_EN(BCAST_EN)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier      (carrier),
    .byte_stb     (byte_stb),
    .byte_q       (byte_q),
    .station_addr (station_addr),
    .crc_val      (crc_val),
    .crc_clr      (crc_clr),
    .crc_en       (crc_en),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .done         (done),
    .status       (status_e)
  );

  assign status = status_e;
endmodule

// File: tb/pkt_rx_framer_tb.sv
module pkt_rx_framer_tb;
  localparam logic [7:0] STN = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] station_addr = STN;
  logic       carrier = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       done;
  logic [1:0] status;

  int n_checks = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  logic [1:0] last_status = 2'b00;
  logic prev_done = 1'b0;
  logic [7:0] got_mem [256];

  always #4 clk = ~clk;

  pkt_rx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .station_addr(station_addr), .carrier(carrier),
    .bit_valid(bit_valid), .bit_data(bit_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .status(status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        got_mem[wr_addr] = wr_data;
        wr_cnt++;
      end
      if (done) begin
        done_cnt++;
        last_status = status;
      end
      if (!done && status != 2'b00) chk(1'b0, "R9", "status while done low", status, 0);
      if (done && prev_done) chk(1'b0, "R9", "done longer than one cycle", 2, 1);
      if (done && wr_en) chk(1'b0, "R9", "write with done", 1, 0);
      prev_done = done;
    end
  end

  // Serial CRC-8, poly 0x07, shift-register form
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic send_bit(input logic b, input int gap);
    bit_valid = 1'b1;
    bit_data  = b;
    @(negedge clk);
    bit_valid = 1'b0;
    bit_data  = ~b;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    for (int i = 0; i < 8; i++) send_bit(b[i], gap);
  endtask

  // cut < 0: whole frame; otherwise only cut bytes are sent
  task automatic run_frame(input logic [7:0] dst, input logic [7:0] src, input int len,
                           input int seed, input logic [7:0] flip, input int cut,
                           input int gap, input int extra);
    logic [7:0] fr [0:259];
    logic [7:0] exp_mem [256];
    bit touched [256];
    logic [7:0] c;
    int nb, nw, mism;
    bit acc;
    fr[0] = dst; fr[1] = src; fr[2] = 8'(len);
    for (int j = 0; j < len; j++) fr[3+j] = 8'((j * seed + len + 7) & 255);
    c = 8'h00;
    for (int k = 0; k < len + 3; k++) c = ref_crc(c, fr[k]);
    fr[len+3] = c ^ flip;
    for (int a = 0; a < 256; a++) begin got_mem[a] = 8'hA5; touched[a] = 0; exp_mem[a] = 8'h00; end
    wr_cnt = 0; done_cnt = 0; last_status = 2'b00;
    carrier = 1'b1;
    @(negedge clk);
    nb = (cut >= 0) ? cut : len + 4;
    for (int k = 0; k < nb; k++) send_byte(fr[k], gap);
    for (int k = 0; k < extra; k++) send_byte(8'(k * 37 + 3), gap);
    repeat (3) @(negedge clk);
    carrier = 1'b0;
    repeat (3) @(negedge clk);
    acc = (dst == STN) || (dst == 8'hFF);
    if (!acc) begin
      // R3 filtered frame leaves the port silent
      chk(wr_cnt == 0, "R3", "writes for other station", wr_cnt, 0);
      chk(done_cnt == 0, "R3", "done for other station", done_cnt, 0);
      return;
    end
    if (cut == 0) begin
      // R11
      chk(done_cnt == 0 && wr_cnt == 0, "R11", "activity on empty carrier", done_cnt + wr_cnt, 0);
      return;
    end
    nw = (cut > 0 && cut < len + 3) ? cut : len + 3;
    for (int k = 0; k < nw; k++) begin exp_mem[k % 256] = fr[k]; touched[k % 256] = 1; end
    chk(wr_cnt == nw, "R4", "write count", wr_cnt, nw);
    mism = 0;
    for (int a = 0; a < 256; a++) if (touched[a] && got_mem[a] !== exp_mem[a]) mism++;
    chk(mism == 0, "R4", "mismatched buffer bytes", mism, 0);
    chk(done_cnt == 1, "R9", "done pulses per frame", done_cnt, 1);
    if (cut >= 0 && cut < len + 4) begin
      chk(last_status == 2'b11, "R8", "runt status", last_status, 3);
    end else if (flip != 0) begin
      chk(last_status == 2'b10, "R7", "check error status", last_status, 2);
    end else begin
      chk(last_status == 2'b01, "R6", "good status", last_status, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(wr_en == 0 && done == 0 && status == 0, "R1", "outputs in reset", {wr_en, done, status}, 0);
    carrier = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_en == 0 && done == 0 && status == 0, "R1", "outputs after reset", {wr_en, done, status}, 0);
    carrier = 1'b0;
    repeat (2) @(negedge clk);

    // R6 R5 R4: length sweep, own address and broadcast
    for (int l = 0; l <= 24; l++) run_frame(STN, 8'h11, l, 3, 8'h00, -1, 0, 0);
    for (int l = 0; l <= 6; l++) run_frame(8'hFF, 8'h22, l, 5, 8'h00, -1, 0, 0);
    // R2: strobe gaps carrying junk data
    for (int g = 1; g <= 3; g++) run_frame(STN, 8'h33, 5, 11, 8'h00, -1, g, 0);
    // R3: every destination value
    for (int d = 0; d < 256; d++) run_frame(8'(d), 8'h44, 1, 1, 8'h00, -1, 0, 0);
    // R7: flipped check bytes
    for (int f = 0; f < 8; f++) run_frame(STN, 8'h55, 4, 9, 8'(1 << f), -1, 0, 0);
    // R8 R11: cut after every byte position
    for (int cpos = 0; cpos <= 7; cpos++) run_frame(STN, 8'h66, 4, 13, 8'h00, cpos, 0, 0);
    // R10: trailing bytes after the check byte, and after a filtered destination
    run_frame(STN, 8'h77, 3, 17, 8'h00, -1, 0, 4);
    run_frame(8'h12, 8'h77, 3, 17, 8'h00, -1, 0, 4);
    // R2: valid bits with carrier low are ignored
    carrier = 1'b0;
    send_byte(8'h3C, 0);
    send_bit(1'b1, 0);
    run_frame(STN, 8'h88, 2, 19, 8'h00, -1, 0, 0);
    // R11: partial byte then carrier drop
    wr_cnt = 0; done_cnt = 0;
    carrier = 1'b1;
    @(negedge clk);
    send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
    repeat (2) @(negedge clk);
    carrier = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_cnt == 0 && wr_cnt == 0, "R11", "partial byte activity", done_cnt + wr_cnt, 0);
    run_frame(STN, 8'h99, 2, 23, 8'h00, -1, 0, 0);
    // R4: maximum payload wraps the write address
    run_frame(STN, 8'hAB, 255, 7, 8'h00, -1, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule